// File: doc/BRIEF.md
# Multiplexed Control-Voltage Refresh Scanner

This block holds a bank of 12-bit control-voltage settings and keeps them alive on a set of analog sample-and-hold channels. All of them share one serial DAC. A host updates a setting over a write-only SPI link, and only when that setting changes. The block itself loops over every channel without help from the host.

For each channel the scanner does four things in order. It takes a copy of the stored value. It shifts that copy into the DAC. It waits a programmable settle time with every multiplexer disabled. Then it enables the one analog multiplexer that serves the channel, on the channel's 3-bit address, for a programmable charge time. One clock with everything deselected follows, and the next channel begins. Eight multiplexers of eight channels give 64 held outputs. Because every channel is revisited on each pass, droop on each hold capacitor stays small.

Top module: `cv_scan_top`

## Requirements
- R1: A host write is one SPI mode-0 frame of exactly 24 bits, sent MSB first, with chip select low for the whole frame. The first 8 bits are the register address and the last 16 are data. Addresses 0 to 63 select a CV channel, which stores the low 12 data bits; the upper 4 data bits are dropped.
- R2: A frame with any bit count other than 24 changes nothing. A write to an address from 66 to 255 changes nothing.
- R3: During and after reset, every channel holds mid-scale 0x800, the settle setting is 4 and the charge setting is 8. While reset is applied, dac_cs_n is high, dac_sclk is low and mux_en is zero. The first DAC frame after reset is for channel 0.
- R4: Channels are visited in the order 0, 1, ..., 63, then 0 again. Channel c is charged through mux_en bit c/8 with mux_addr equal to c mod 8.
- R5: Each DAC frame holds dac_cs_n low for 32 clocks. It carries 16 bits MSB first, and each bit takes 2 clocks: dac_sclk low, then high. The word is four zero bits followed by the 12-bit value. dac_sclk stays low while dac_cs_n is high.
- R6: After dac_cs_n returns high, mux_en stays zero for settle+1 clocks. The settle setting is written at address 64, using its low 8 data bits.
- R7: mux_en is high for exactly charge+1 clocks, with at most one bit set and mux_addr and mux_en steady throughout. The charge setting is written at address 65, using its low 8 data bits.
- R8: Exactly one clock with mux_en zero and dac_cs_n high lies between the end of a charge and the start of the next DAC frame.
- R9: Each channel's value is copied when its DAC frame starts. A write landing at any other time, including while that channel is enabled, appears on the channel's next visit. It never alters a frame or charge already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Host SPI clock (mode 0) |
| spi_cs_n | input | 1 | Host SPI chip select, active low |
| spi_mosi | input | 1 | Host SPI data in |
| dac_sclk | output | 1 | DAC serial clock |
| dac_cs_n | output | 1 | DAC chip select, low for one frame; the rising edge latches the DAC |
| dac_din | output | 1 | DAC serial data, MSB first |
| mux_addr | output | 3 | Channel address within the selected multiplexer |
| mux_en | output | 8 | One enable per multiplexer, at most one high |

## Verification
A wrong channel counter or value copy shows up on the very next DAC frame, within about 50 clocks. The frame has the wrong value, or the mux_en bit and mux_addr do not match the expected channel. A corrupted settle or charge counter shows up within one channel slot as a wrong low-gap or enable-width count. A missed or misplaced register write surfaces only when that channel's turn comes round, at most one full pass (about 3,000 clocks with the default timing). For that reason the bench follows every pending write until it reaches the DAC.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
    typedef enum logic [1:0] {
        SC_GAP    = 2'd0,
        SC_LOAD   = 2'd1,
        SC_SETTLE = 2'd2,
        SC_CHARGE = 2'd3
    } scan_state_e;
endpackage

// File: rtl/cvs_spi_rx.sv
module cvs_spi_rx #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [2:0]         sync1;      // {sclk, cs_n, mosi}
        logic [2:0]         sync2;
        logic               sclk_prev;
        logic               cs_prev;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               wr;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d       = q;
        d.sync1 = {spi_sclk, spi_cs_n, spi_mosi};
        d.sync2 = q.sync1;
        d.sclk_prev = q.sync2[2];
        d.cs_prev   = q.sync2[1];
        d.wr        = 1'b0;
        if (!q.sync2[1]) begin
            if (q.sync2[2] && !q.sclk_prev) begin
                d.shreg = {q.shreg[FRAME_W-2:0], q.sync2[0]};
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
            if (!q.cs_prev) d.wr = (q.cnt == CNT_W'(FRAME_W));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.sync1   <= 3'b010;
            q.sync2   <= 3'b010;
            q.cs_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_valid = q.wr;
    assign wr_addr  = q.shreg[FRAME_W-1 -: ADDR_W];
    assign wr_data  = q.shreg[DATA_W-1:0];
endmodule

// File: rtl/cvs_regfile.sv
module cvs_regfile #(
    parameter int NUM_CH     = 64,
    parameter int VAL_W      = 12,
    parameter int TIME_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int SETTLE_RST = 4,
    parameter int CHARGE_RST = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(NUM_CH)-1:0] rd_idx,
    output logic [VAL_W-1:0]          rd_data,
    output logic [TIME_W-1:0]         settle_cfg,
    output logic [TIME_W-1:0]         charge_cfg
);
    localparam logic [VAL_W-1:0]  MID_SCALE   = VAL_W'(1) << (VAL_W - 1);
    localparam logic [ADDR_W-1:0] SETTLE_ADDR = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] CHARGE_ADDR = ADDR_W'(NUM_CH + 1);

    logic [VAL_W-1:0] cv_q [NUM_CH];
    logic             unused_hi;
    assign unused_hi = ^wr_data[DATA_W-1:VAL_W];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [VAL_W-1:0] cv_d;
        always_comb begin
            cv_d = cv_q[g];
            if (wr_valid && wr_addr == ADDR_W'(g)) cv_d = wr_data[VAL_W-1:0];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cv_q[g] <= MID_SCALE;
            else        cv_q[g] <= cv_d;
        end
    end

    typedef struct packed {
        logic [TIME_W-1:0] settle;
        logic [TIME_W-1:0] charge;
    } tcfg_t;

    tcfg_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (wr_valid && wr_addr == SETTLE_ADDR) t_d.settle = wr_data[TIME_W-1:0];
        if (wr_valid && wr_addr == CHARGE_ADDR) t_d.charge = wr_data[TIME_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.settle <= TIME_W'(SETTLE_RST);
            t_q.charge <= TIME_W'(CHARGE_RST);
        end else begin
            t_q <= t_d;
        end
    end

    assign rd_data    = cv_q[rd_idx];
    assign settle_cfg = t_q.settle;
    assign charge_cfg = t_q.charge;
endmodule

// File: rtl/cvs_scan.sv
module cvs_scan
    import cvs_pkg::*;
#(
    parameter int NUM_MUX = 8,
    parameter int MUX_W   = 3,
    parameter int VAL_W   = 12,
    parameter int TIME_W  = 8,
    parameter int DAC_W   = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [TIME_W-1:0]                       settle_cfg,
    input  logic [TIME_W-1:0]                       charge_cfg,
    input  logic [VAL_W-1:0]                        rd_data,
    output logic [$clog2(NUM_MUX * (1 << MUX_W))-1:0] rd_idx,
    output logic                                    dac_sclk,
    output logic                                    dac_cs_n,
    output logic                                    dac_din,
    output logic [MUX_W-1:0]                        mux_addr,
    output logic [NUM_MUX-1:0]                      mux_en
);
    localparam int NUM_CH = NUM_MUX * (1 << MUX_W);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int BIT_W  = $clog2(DAC_W);
    localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DAC_W - 1);

    typedef struct packed {
        scan_state_e       st;
        logic [CH_W-1:0]   ch;
        logic [BIT_W-1:0]  bit_idx;
        logic              sclk;
        logic [TIME_W-1:0] cnt;
        logic [DAC_W-1:0]  shreg;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            SC_GAP: begin
                d.shreg   = DAC_W'(rd_data);
                d.bit_idx = '0;
                d.sclk    = 1'b0;
                d.st      = SC_LOAD;
            end
            SC_LOAD: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                end else begin
                    d.sclk  = 1'b0;
                    d.shreg = {q.shreg[DAC_W-2:0], 1'b0};
                    if (q.bit_idx == LAST_BIT) begin
                        d.st  = SC_SETTLE;
                        d.cnt = settle_cfg;
                    end else begin
                        d.bit_idx = q.bit_idx + 1'b1;
                    end
                end
            end
            SC_SETTLE: begin
                if (q.cnt == '0) begin
                    d.st  = SC_CHARGE;
                    d.cnt = charge_cfg;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SC_CHARGE: begin
                if (q.cnt == '0) begin
                    d.st = SC_GAP;
                    d.ch = (q.ch == LAST_CH) ? '0 : q.ch + 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = SC_GAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SC_GAP;
        end else begin
            q <= d;
        end
    end

    assign rd_idx   = q.ch;
    assign dac_sclk = q.sclk;
    assign dac_cs_n = (q.st != SC_LOAD);
    assign dac_din  = (q.st == SC_LOAD) ? q.shreg[DAC_W-1] : 1'b0;
    assign mux_addr = q.ch[MUX_W-1:0];

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_en
        assign mux_en[m] = (q.st == SC_CHARGE) && ((q.ch >> MUX_W) == CH_W'(m));
    end
endmodule

// File: rtl/cv_scan_top.sv
module cv_scan_top #(
    parameter int NUM_MUX    = 8,
    parameter int MUX_W      = 3,
    parameter int VAL_W      = 12,
    parameter int TIME_W     = 8,
    parameter int DAC_W      = 16,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int SETTLE_RST = 4,
    parameter int CHARGE_RST = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               dac_sclk,
    output logic               dac_cs_n,
    output logic               dac_din,
    output logic [MUX_W-1:0]   mux_addr,
    output logic [NUM_MUX-1:0] mux_en
);
    localparam int NUM_CH = NUM_MUX * (1 << MUX_W);
    localparam int CH_W   = $clog2(NUM_CH);

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [CH_W-1:0]   rd_idx;
    logic [VAL_W-1:0]  rd_data;
    logic [TIME_W-1:0] settle_cfg;
    logic [TIME_W-1:0] charge_cfg;

    cvs_spi_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    cvs_regfile #(
        .NUM_CH(NUM_CH), .VAL_W(VAL_W), .TIME_W(TIME_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .SETTLE_RST(SETTLE_RST), .CHARGE_RST(CHARGE_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .settle_cfg(settle_cfg), .charge_cfg(charge_cfg)
    );

    cvs_scan #(
        .NUM_MUX(NUM_MUX), .MUX_W(MUX_W), .VAL_W(VAL_W),
        .TIME_W(TIME_W), .DAC_W(DAC_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n),
        .settle_cfg(settle_cfg), .charge_cfg(charge_cfg),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_din(dac_din),
        .mux_addr(mux_addr), .mux_en(mux_en)
    );
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
    parameter int NUM_MUX = 8,
    parameter int MUX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dac_sclk,
    input logic               dac_cs_n,
    input logic [MUX_W-1:0]   mux_addr,
    input logic [NUM_MUX-1:0] mux_en
);
    // R7: never more than one multiplexer enabled
    a_r7_single_mux: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mux_en));

    // R7: selection frozen while a charge is under way
    a_r7_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mux_en) && $past(|mux_en)) |-> ($stable(mux_addr) && $stable(mux_en)));

    // R9: the DAC is never reloaded while a hold channel is charging
    a_r9_no_load_while_en: assert property (@(posedge clk) disable iff (!rst_n)
        (|mux_en) |-> dac_cs_n);

    // R6: enable rises only after the DAC frame has closed
    a_r6_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|mux_en) |-> ($past(dac_cs_n) && !$past(|mux_en)));

    // R5: DAC clock idles low outside a frame
    a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);

    // R8: a new frame never starts straight out of a charge
    a_r8_gap_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> (mux_en == '0 && $past(mux_en) == '0));
endmodule

bind cv_scan_top cvs_checker #(.NUM_MUX(NUM_MUX), .MUX_W(MUX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n),
    .mux_addr(mux_addr), .mux_en(mux_en)
);

// File: tb/tb_cv_scan_top.sv
module tb_cv_scan_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic dac_sclk, dac_cs_n, dac_din;
    logic [2:0] mux_addr;
    logic [7:0] mux_en;

    always #2.5 clk = ~clk;   // 200 MHz

    cv_scan_top dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n),
        .dac_din(dac_din), .mux_addr(mux_addr), .mux_en(mux_en)
    );

    int checks = 0, errors = 0, cyc = 0;
    int model [64], old_m [64], wr_cyc [64];
    int settle_m = 4, charge_m = 8, tim_wr_cyc = -100000;

    typedef struct { int ch; int val; int cyc; } pend_t;
    pend_t pq [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // driver: sends nbits of a 24-bit word, MSB first, mode 0
    task automatic spi_frame(input logic [23:0] w, input int nbits, input logic extra);
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 24) ? w[23 - i] : extra;
            repeat (4) @(negedge clk); spi_sclk = 1'b1;
            repeat (4) @(negedge clk); spi_sclk = 1'b0;
        end
        repeat (2) @(negedge clk); spi_cs_n = 1'b1;
    endtask

    task automatic host_write(input int addr, input int data);
        spi_frame({addr[7:0], data[15:0]}, 24, 1'b0);
        if (addr < 64) begin
            old_m[addr]  = model[addr];
            model[addr]  = data & 'hFFF;
            wr_cyc[addr] = cyc;
            for (int i = pq.size() - 1; i >= 0; i--) if (pq[i].ch == addr) pq.delete(i);
            pq.push_back('{addr, data & 'hFFF, cyc});
        end else if (addr == 64) begin
            settle_m = data & 'hFF; tim_wr_cyc = cyc;
        end else if (addr == 65) begin
            charge_m = data & 'hFF; tim_wr_cyc = cyc;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < n; i++) @(posedge dac_cs_n);
    endtask

    // monitor
    int exp_ch = 0, phase = 0, bits = 0, s_cnt = 0, c_cnt = 0, g_cnt = 0;
    int exp_new, exp_old, f_start;
    bit amb, seen = 0, prev_cs = 1, prev_sclk = 0;
    logic [15:0] word;
    logic [7:0] en_hold;
    logic [2:0] addr_hold;

    always @(negedge clk) begin
        if (rst_n) begin
            bit tim_ok;
            tim_ok = (cyc - tim_wr_cyc) > 400;
            if (prev_cs && !dac_cs_n) begin
                if (seen) chk(g_cnt == 1, "R8 gap clocks", g_cnt, 1);
                seen = 1; bits = 0; word = '0; phase = 0; f_start = cyc;
                exp_new = model[exp_ch]; exp_old = old_m[exp_ch];
                amb = (cyc - wr_cyc[exp_ch]) <= 12;
            end
            if (!dac_cs_n && !prev_sclk && dac_sclk) begin
                word = {word[14:0], dac_din}; bits++;
            end
            if (!prev_cs && dac_cs_n) begin
                chk(bits == 16, "R5 bits per frame", bits, 16);
                chk(word[15:12] == 4'h0, "R5 pad bits", word[15:12], 0);
                chk(word[11:0] == exp_new[11:0] || (amb && word[11:0] == exp_old[11:0]),
                    "R9 dac value", word[11:0], exp_new);
                for (int i = 0; i < pq.size(); i++) begin
                    if (pq[i].ch == exp_ch && (f_start - pq[i].cyc) > 12) begin
                        chk(word[11:0] == pq[i].val[11:0], "R1 write reached DAC", word[11:0], pq[i].val);
                        pq.delete(i);
                        break;
                    end
                end
                phase = 1; s_cnt = 1;
            end else if (phase == 1) begin
                if (mux_en == 8'h00) s_cnt++;
                else begin
                    if (tim_ok) chk(s_cnt == settle_m + 1, "R6 settle clocks", s_cnt, settle_m + 1);
                    chk(mux_en == (8'h01 << (exp_ch / 8)), "R4 mux enable", mux_en, 8'h01 << (exp_ch / 8));
                    chk(mux_addr == exp_ch[2:0], "R4 mux address", mux_addr, exp_ch % 8);
                    en_hold = mux_en; addr_hold = mux_addr;
                    phase = 2; c_cnt = 1;
                end
            end else if (phase == 2) begin
                if (mux_en != 8'h00) begin
                    c_cnt++;
                    if (mux_en != en_hold || mux_addr != addr_hold)
                        chk(0, "R7 selection steady", {mux_en, 5'b0, mux_addr}, {en_hold, 5'b0, addr_hold});
                end else begin
                    if (tim_ok) chk(c_cnt == charge_m + 1, "R7 charge clocks", c_cnt, charge_m + 1);
                    phase = 3; g_cnt = 1;
                    exp_ch = (exp_ch + 1) % 64;
                end
            end else if (phase == 3 && dac_cs_n) begin
                g_cnt++;
            end
        end
        prev_cs = dac_cs_n; prev_sclk = dac_sclk;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin model[i] = 'h800; old_m[i] = 'h800; wr_cyc[i] = -100000; end
        repeat (5) @(negedge clk);
        chk(dac_cs_n == 1'b1, "R3 reset cs_n", dac_cs_n, 1);
        chk(dac_sclk == 1'b0, "R3 reset sclk", dac_sclk, 0);
        chk(mux_en == 8'h00, "R3 reset enables", mux_en, 0);
        rst_n = 1'b1;
        wait_frames(66);                       // R3/R4: full pass at mid-scale

        host_write(0, 'h0FFF);
        host_write(7, 'h0000);
        host_write(8, 'hF123);                 // R1: upper bits dropped
        host_write(63, 'h0555);
        host_write(35, 'h0ABC);
        wait_frames(130);

        host_write(64, 'h000A);                // R6
        host_write(65, 'hFF14);                // R7: low 8 bits = 20
        wait_frames(130);

        spi_frame({8'd5, 16'h00AA}, 23, 1'b0); // R2: short frame
        spi_frame({8'd6, 16'h00BB}, 25, 1'b1); // R2: long frame
        host_write(66, 'h0001);                // R2: unused address
        host_write(200, 'h0002);
        wait_frames(130);

        host_write(65, 255);                   // R9: long charge window
        repeat (100) @(negedge clk);
        wait (mux_en == 8'h00);
        wait (mux_en == 8'h04 && mux_addr == 3'd4);
        @(negedge clk);
        host_write(20, 'h02AB);
        chk(mux_en == 8'h04 && mux_addr == 3'd4, "R9 charge not disturbed", mux_en, 8'h04);
        chk(dac_cs_n == 1'b1, "R9 no reload during charge", dac_cs_n, 1);
        wait_frames(70);

        host_write(64, 4);
        host_write(65, 8);
        wait_frames(130);
        chk(pq.size() == 0, "R9 all writes delivered", pq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule